// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Reduced Instruction Set

This block is a serial test port for a host device. It is clocked by the test clock and steered by a mode-select input. It shifts serial data in and out through one of four scan paths: a 3-bit instruction register, a 1-bit pass-through stage, a 32-bit identity word, or a parameterized chain of pin cells. The standard sixteen-state controller sequences capture, shift and update. The instruction that is in force chooses the data path. It also tells the host whether to float its outputs.

The instruction set is not fully compliant. The all-zero code captures and shifts the pin chain like the sample/preload code, and it also forces the host outputs off. A separate code, 010, also forces the host outputs off while the pin chain is scanned. Codes 011, 101 and 110 are reserved and act as the pass-through code. The pin chain has a parallel hold latch, `bsr_out`. The latch takes the shifted pattern on update, but only while a pin-chain code is in force.

Top module: `scan_tap`

## Requirements
- R1: From any controller state, five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset. On the next edge the instruction becomes 001 (identity), so `host_hiz` falls to 0 and the next data scan returns the identity word.
- R2: In Capture-IR the instruction shift stage loads 3'b001. The first three bits out of `tdo` in Shift-IR are therefore 1, 0, 0.
- R3: With instruction 001, a data scan returns the 32-bit word {REV_ID[2:0], PART_ID[16:0], MFR_ID[10:0], 1'b1}, least significant bit first.
- R4: With instruction 111, the data path is a single stage. It captures 0 and then delays `tdi` by one shift.
- R5: The reserved codes 011, 101 and 110 behave exactly like 111.
- R6: `host_hiz` is 1 while the instruction is 000 or 010 and 0 for every other code. It changes only when a new instruction is applied on leaving Update-IR, or on a controller reset.
- R7: With codes 000, 010 or 100, Capture-DR loads `pin_in` into the pin chain, which then shifts out LSB first while `tdi` enters at the MSB. On leaving Update-DR, `bsr_out` takes the shifted contents. `bsr_out` changes at no other time except under `rst`.
- R8: `tdo` and `tdo_oe` change only on falling edges of `clk`. `tdo_oe` is 1 exactly during the half cycles that follow a rising edge entering or staying in Shift-IR or Shift-DR.
- R9: A synchronous `rst` puts the controller in Test-Logic-Reset, the instruction to 001, `tdo_oe` to 0, `host_hiz` to 0 and `bsr_out` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; inputs sampled on rising edge, `tdo` launched on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Controller mode select |
| tdi | input | 1 | Serial data into the MSB of the selected path |
| pin_in | input | BSR_LEN | Host pin states captured into the pin chain |
| tdo | output | 1 | Serial data from the LSB of the selected path |
| tdo_oe | output | 1 | High while `tdo` carries valid shift data |
| host_hiz | output | 1 | Request that the host float its outputs |
| bsr_out | output | BSR_LEN | Parallel hold latch of the pin chain |

## Verification
The hardest situation to reach is an instruction that forces the outputs off while the controller runs data scans and detours through pause states. Under those conditions `host_hiz` must stay put until the next Update-IR or a five-edge reset. The stimulus loads code 010 and runs full pin-chain scans with preload. It then parks the controller in Pause-DR and escapes with five `tms` highs, so the hold behaviour and the reset path are both exercised under an active output-disable. A behavioural state table in the bench predicts every output on every cycle.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXT = 3'b000;
    localparam logic [IR_W-1:0] OP_IDC = 3'b001;
    localparam logic [IR_W-1:0] OP_HIZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SMP = 3'b100;
    localparam logic [IR_W-1:0] OP_BYP = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     host_off;
        logic     upd_ok;
    } op_decode_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            S_RESET:  n = tms ? S_RESET  : S_IDLE;
            S_IDLE:   n = tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: n = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: n = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  n = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: n = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: n = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: n = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: n = tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: n = tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: n = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  n = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: n = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: n = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: n = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: n = tms ? S_SEL_DR : S_IDLE;
            default:  n = S_RESET;
        endcase
        return n;
    endfunction

    function automatic op_decode_t op_decode(logic [IR_W-1:0] op);
        op_decode_t d;
        case (op)
            OP_IDC:         d = '{path: PATH_ID,  host_off: 1'b0, upd_ok: 1'b0};
            OP_EXT, OP_HIZ: d = '{path: PATH_BSR, host_off: 1'b1, upd_ok: 1'b1};
            OP_SMP:         d = '{path: PATH_BSR, host_off: 1'b0, upd_ok: 1'b1};
            default:        d = '{path: PATH_BYP, host_off: 1'b0, upd_ok: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic [ID_W-1:0] id_word(logic [2:0] rev, logic [16:0] part,
                                                 logic [10:0] mfr);
        return {rev, part, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= S_RESET;
        else     state <= tap_next(state, tms);
    end

    // count of consecutive tms-high edges, saturating at five
    logic [2:0] tms_run;
    always_ff @(posedge clk) begin
        if (rst)            tms_run <= '0;
        else if (!tms)      tms_run <= '0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    assert_five_high_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (tms_run == 3'd5) |-> (state == S_RESET));
endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] instr,
    output logic            ir_lsb
);
    logic [IR_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= IR_CAPTURE;
            instr <= OP_IDC;
        end else begin
            case (state)
                S_RESET:  instr <= OP_IDC;
                S_CAP_IR: sh_q  <= IR_CAPTURE;
                S_SH_IR:  sh_q  <= {tdi, sh_q[IR_W-1:1]};
                S_UPD_IR: instr <= sh_q;
                default: ;
            endcase
        end
    end

    assign ir_lsb = sh_q[0];

    assert_capture_pattern_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_CAP_IR) |=> (sh_q[1:0] == 2'b01));
    assert_reset_idcode_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_RESET) |=> (instr == OP_IDC));
    assert_instr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state != S_UPD_IR && state != S_RESET) |=> $stable(instr));
endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              BSR_LEN = 70,
    parameter logic [ID_W-1:0] ID_WORD = 32'h1
) (
    input  logic               clk,
    input  logic               rst,
    input  tap_state_e         state,
    input  logic               tdi,
    input  dr_path_e           path,
    input  logic               upd_ok,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_out
);
    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q   <= 1'b0;
            id_q    <= ID_WORD;
            bsr_q   <= '0;
            bsr_out <= '0;
        end else begin
            case (state)
                S_CAP_DR: begin
                    case (path)
                        PATH_ID:  id_q  <= ID_WORD;
                        PATH_BSR: bsr_q <= pin_in;
                        default:  byp_q <= 1'b0;
                    endcase
                end
                S_SH_DR: begin
                    case (path)
                        PATH_ID:  id_q  <= {tdi, id_q[ID_W-1:1]};
                        PATH_BSR: bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
                        default:  byp_q <= tdi;
                    endcase
                end
                S_UPD_DR: if (upd_ok) bsr_out <= bsr_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_lsb = id_q[0];
            PATH_BSR: dr_lsb = bsr_q[0];
            default:  dr_lsb = byp_q;
        endcase
    end

    assert_bypass_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_CAP_DR && path == PATH_BYP) |=> (dr_lsb == 1'b0));
    assert_id_marker_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_CAP_DR && path == PATH_ID) |=> (dr_lsb == 1'b1));
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state != S_UPD_DR) |=> $stable(bsr_out));
endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN = 70,
    parameter logic [2:0]  REV_ID  = 3'h2,
    parameter logic [16:0] PART_ID = 17'h0A5C3,
    parameter logic [10:0] MFR_ID  = 11'h0B5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               host_hiz,
    output logic [BSR_LEN-1:0] bsr_out
);
    localparam logic [ID_W-1:0] ID_WORD = id_word(REV_ID, PART_ID, MFR_ID);

    tap_state_e      state;
    logic [IR_W-1:0] instr;
    logic            ir_lsb;
    logic            dr_lsb;
    op_decode_t      dec;
    logic            shifting;

    scan_tap_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    scan_tap_ir u_ir (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .tdi    (tdi),
        .instr  (instr),
        .ir_lsb (ir_lsb)
    );

    assign dec      = op_decode(instr);
    assign host_hiz = dec.host_off;

    scan_tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .tdi     (tdi),
        .path    (dec.path),
        .upd_ok  (dec.upd_ok),
        .pin_in  (pin_in),
        .dr_lsb  (dr_lsb),
        .bsr_out (bsr_out)
    );

    assign shifting = (state == S_SH_DR) || (state == S_SH_IR);

    // launch on the falling edge, half a cycle after the state settles
    always_ff @(negedge clk) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shifting;
            tdo    <= shifting ? ((state == S_SH_IR) ? ir_lsb : dr_lsb) : 1'b0;
        end
    end

    assert_oe_follows_shift_R8: assert property (@(posedge clk) disable iff (rst)
        tdo_oe == shifting);
endmodule

// File: tb/scan_tap_tb.sv
module scan_tap_tb;
    localparam int N = 70;
    localparam logic [31:0] EXP_ID = {3'h2, 17'h0A5C3, 11'h0B5, 1'b1};
    localparam logic [N-1:0] PIN_A = {6'h15, 64'hC3A5_0F96_1E2D_7B48};
    localparam logic [N-1:0] PIN_B = {6'h3A, 64'h0F0F_5A5A_9696_1234};
    localparam logic [N-1:0] PAT_P = {6'h2B, 64'h1357_9BDF_0246_8ACE};

    logic clk = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic [N-1:0] pin_in = PIN_A;
    logic tdo, tdo_oe, host_hiz;
    logic [N-1:0] bsr_out;

    always #2 clk = ~clk;

    scan_tap u_dut (
        .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .host_hiz(host_hiz), .bsr_out(bsr_out)
    );

    int tests = 0, fails = 0;

    // behavioural reference: state numbers are the bench's own
    int nx0 [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
    int nx1 [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};
    int m_st = 0;
    logic [2:0] m_ir = 3'b001, m_irsh = 3'b001;
    logic m_byp = 1'b0, m_oe = 1'b0, m_tdo = 1'b0;
    logic [31:0] m_id = EXP_ID;
    logic [N-1:0] m_bsr = '0, m_upd = '0;

    function automatic int m_path(logic [2:0] op);
        if (op == 3'b001) return 1;
        if (op == 3'b000 || op == 3'b010 || op == 3'b100) return 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_rise();
        int p;
        p = m_path(m_ir);
        if (rst) begin
            m_st = 0; m_ir = 3'b001; m_upd = '0; m_bsr = '0; m_byp = 1'b0; m_id = EXP_ID;
            return;
        end
        case (m_st)
            0:  m_ir = 3'b001;
            10: m_irsh = 3'b001;
            11: m_irsh = {tdi, m_irsh[2:1]};
            15: m_ir = m_irsh;
            3:  if (p == 1) m_id = EXP_ID; else if (p == 2) m_bsr = pin_in; else m_byp = 1'b0;
            4:  if (p == 1) m_id = {tdi, m_id[31:1]};
                else if (p == 2) m_bsr = {tdi, m_bsr[N-1:1]};
                else m_byp = tdi;
            8:  if (p == 2) m_upd = m_bsr;
            default: ;
        endcase
        m_st = tms ? nx1[m_st] : nx0[m_st];
    endtask

    task automatic model_fall();
        int p;
        p = m_path(m_ir);
        if (rst) begin m_oe = 1'b0; m_tdo = 1'b0; return; end
        m_oe = (m_st == 4 || m_st == 11);
        if (m_st == 11) m_tdo = m_irsh[0];
        else m_tdo = (p == 1) ? m_id[0] : (p == 2) ? m_bsr[0] : m_byp;
    endtask

    task automatic compare();
        logic exp_hiz;
        exp_hiz = (m_ir == 3'b000 || m_ir == 3'b010);
        check(tdo_oe === m_oe, "R8 tdo_oe", 128'(tdo_oe), 128'(m_oe));
        if (m_oe) check(tdo === m_tdo, "R8 tdo", 128'(tdo), 128'(m_tdo));
        check(host_hiz === exp_hiz, "R6 host_hiz", 128'(host_hiz), 128'(exp_hiz));
        check(bsr_out === m_upd, "R7 bsr_out", 128'(bsr_out), 128'(m_upd));
    endtask

    task automatic tick(input logic t_tms, input logic t_tdi);
        logic pre_tdo, pre_oe;
        tms = t_tms; tdi = t_tdi;
        pre_tdo = tdo; pre_oe = tdo_oe;
        @(posedge clk);
        model_rise();
        #1;
        check(tdo === pre_tdo && tdo_oe === pre_oe, "R8 no change at rising edge",
              128'({tdo_oe, tdo}), 128'({pre_oe, pre_tdo}));
        @(negedge clk);
        model_fall();
        #1;
        compare();
    endtask

    // from Run-Test/Idle: load an instruction, return captured bits
    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            tick(i == 2, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // from Run-Test/Idle: full data scan, return shifted-out bits
    task automatic scan_dr(input logic [127:0] din, input int len, output logic [127:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            tick(i == len - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    logic [2:0] cap;
    logic [127:0] dout;

    initial begin
        repeat (50000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        rst = 1'b1;
        repeat (3) tick(1, 0);
        // R9 reset state
        check(tdo_oe == 1'b0 && host_hiz == 1'b0 && bsr_out == '0, "R9 reset outputs",
              128'({tdo_oe, host_hiz, bsr_out}), 128'(0));
        rst = 1'b0;
        tick(0, 0);

        // R3 identity after reset
        scan_dr(128'h0, 32, dout);
        check(dout[31:0] == EXP_ID, "R3 identity word", dout, 128'(EXP_ID));

        // R2 capture pattern; R4 pass-through
        load_ir(3'b111, cap);
        check(cap == 3'b001, "R2 IR capture bits", 128'(cap), 128'(3'b001));
        scan_dr(128'hB5, 8, dout);
        check(dout[0] == 1'b0, "R4 pass-through captures 0", dout[0], 0);
        check(dout[7:1] == 7'h35, "R4 one-stage delay", 128'(dout[7:1]), 128'(7'h35));

        // R5 reserved codes
        for (int k = 0; k < 3; k++) begin
            logic [2:0] op;
            op = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            load_ir(op, cap);
            scan_dr(128'h6C, 8, dout);
            check(dout[7:0] == 8'hD8, "R5 reserved acts as pass-through", 128'(dout[7:0]), 128'(8'hD8));
        end

        // R6/R7 sample-preload
        load_ir(3'b100, cap);
        check(host_hiz == 1'b0, "R6 code 100 leaves host on", 128'(host_hiz), 0);
        scan_dr(128'(PAT_P), N, dout);
        check(dout[N-1:0] == PIN_A, "R7 capture of pin_in", dout, 128'(PIN_A));
        check(bsr_out == PAT_P, "R7 update latch", 128'(bsr_out), 128'(PAT_P));

        // R6 all-zero code forces outputs off and preloads
        load_ir(3'b000, cap);
        check(host_hiz == 1'b1, "R6 code 000 floats host", 128'(host_hiz), 1);
        pin_in = PIN_B;
        scan_dr(128'(PIN_A), N, dout);
        check(dout[N-1:0] == PIN_B, "R7 capture second pattern", dout, 128'(PIN_B));
        check(bsr_out == PIN_A, "R7 update second pattern", 128'(bsr_out), 128'(PIN_A));

        // R6 code 010 holds through data scans; R1 five-high escape from Pause-DR
        load_ir(3'b010, cap);
        check(host_hiz == 1'b1, "R6 code 010 floats host", 128'(host_hiz), 1);
        scan_dr(128'(PAT_P), N, dout);
        check(host_hiz == 1'b1, "R6 hold across data scan", 128'(host_hiz), 1);
        tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        repeat (5) tick(1, 0);
        tick(1, 0);
        check(host_hiz == 1'b0 && tdo_oe == 1'b0, "R1 reset by five highs",
              128'({host_hiz, tdo_oe}), 0);
        tick(0, 0);
        scan_dr(128'h0, 32, dout);
        check(dout[31:0] == EXP_ID, "R1 identity after five highs", dout, 128'(EXP_ID));

        // R9 synchronous reset in mid shift
        load_ir(3'b100, cap);
        scan_dr(128'(PAT_P), N, dout);
        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
        rst = 1'b1;
        tick(0, 0);
        check(tdo_oe == 1'b0 && bsr_out == '0 && host_hiz == 1'b0, "R9 reset mid scan",
              128'({tdo_oe, host_hiz, bsr_out}), 0);
        rst = 1'b0;
        tick(0, 0);
        scan_dr(128'h0, 32, dout);
        check(dout[31:0] == EXP_ID, "R9 identity after reset", dout, 128'(EXP_ID));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule